// File: doc/BRIEF.md
# I2C controller interrupt and abort unit

This unit sits next to the byte-command engine of an I2C master and gathers everything that can raise its interrupt. Single-cycle event pulses from the engine (start or repeated start seen, stop seen, bus activity, general call, transfer abort with a cause vector) and the FIFO strobes (write to a full transmit FIFO, received byte dropped, read from an empty receive FIFO) set sticky flags. Two more flags follow the FIFO fill levels against programmable thresholds and clear themselves. The raw flags, ANDed with a mask register, drive one combined interrupt line.

Software reaches the unit through a plain register port with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` is combinational and valid in the same cycle as `reg_rd`. A read of a clear location returns the flag's value from before the clear, and the flag is cleared at the edge that ends the read. While the abort flag is set, `tx_flush` holds the transmit FIFO flushed. Reading the abort clear location or the global clear location releases it.

Register map (word addresses on `reg_addr`): 0x00 raw status, 0x01 masked status, 0x02 mask, 0x03 receive threshold, 0x04 transmit threshold, 0x05 abort cause, 0x10 clear all. The individual clear locations are 0x11 receive underflow, 0x12 receive overflow, 0x13 transmit overflow, 0x14 abort, 0x15 activity, 0x16 stop, 0x17 start, 0x18 general call. Any other address reads as zero.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset the mask reads 0x8FF, both thresholds read 0, the abort cause reads 0 and every sticky flag is clear. Raw status bits 5, 7 and 12 to 31 always read 0.
- R2: A threshold register stores 8 bits and reads back as written. For comparison, any programmed value above 16 acts as 16, the FIFO depth.
- R3: Raw bit 4 (transmit low) is 1 exactly while `tx_level` is less than or equal to the effective transmit threshold.
- R4: Raw bit 2 (receive high) is 1 exactly while `rx_level` is greater than or equal to the effective receive threshold.
- R5: Each sticky event sets its raw bit one cycle after its pulse: general call bit 11, start bit 10, stop bit 9, activity bit 8, transmit overflow bit 3, receive overflow bit 1, receive underflow bit 0. The flag stays set until its own clear location or the global clear location is read.
- R6: `ev_abort` sets raw bit 6 and `tx_flush` and ORs the cause into the cause register, keeping only bits 0-5, 7, 9, 10, 12 and 16 (valid mask 0x116BF). A read of location 0x14 clears bit 6, the cause register and `tx_flush`.
- R7: While `bus_active` is 1, neither the activity clear read nor the global clear read changes the activity flag.
- R8: A read of the global clear location clears every sticky flag (subject to R7) and the cause register. Raw bits 4 and 2 are left as they are.
- R9: The masked status equals the raw status ANDed with the mask (bits 11:0). `irq` is 1 exactly when the masked status is nonzero.
- R10: A read of a clear location returns 1 in bit 0 when the targeted flag was set before the read, and 0 in all other bits. For the global location the targeted flag is any sticky flag.
- R11: When an event pulse and a read of its clear location fall in the same cycle, the flag is set afterwards. For an abort, the cause register then holds the new cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_gen_call | input | 1 | General call event pulse |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_activity | input | 1 | Bus activity pulse |
| ev_abort | input | 1 | Transfer abort pulse |
| abort_cause | input | 17 | Cause bits qualifying `ev_abort` |
| bus_active | input | 1 | Bus is still busy (level) |
| tx_level | input | 5 | Transmit FIFO fill level, 0 to 16 |
| rx_level | input | 5 | Receive FIFO fill level, 0 to 16 |
| ev_tx_wr_full | input | 1 | Write attempted on full transmit FIFO |
| ev_rx_drop | input | 1 | Received byte lost to a full receive FIFO |
| ev_rx_rd_empty | input | 1 | Read attempted on empty receive FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle as `reg_rd` |
| irq | output | 1 | Combined interrupt |
| tx_flush | output | 1 | Hold the transmit FIFO flushed |

## Verification
The hardest cases to reach are a clear read landing in the same cycle as the event it would erase, and an activity clear while the bus is still busy. Neither occurs in ordinary driver traffic. The bench's step task drives an event vector and a register read within one cycle window, so directed cases place a stop pulse or an abort on top of its own clear read. The random phase then mixes events, clears, `bus_active` toggles, level changes and threshold values above the FIFO depth. A reference model checks raw status, masked status, `irq` and `tx_flush` after every step.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int IRQ_W    = 12;
  localparam int CAUSE_W  = 17;
  localparam int REG_AW   = 5;
  localparam int N_STICKY = 8;

  localparam int B_RXF = 2;
  localparam int B_TXE = 4;

  // sticky flag k sits at raw bit STICKY_BIT[k]; its clear location is A_CLR_BASE + k
  localparam int STICKY_BIT [N_STICKY] = '{0, 1, 3, 6, 8, 9, 10, 11};
  localparam int K_ABRT = 3;
  localparam int K_ACT  = 4;

  localparam logic [IRQ_W-1:0]   MASK_RST    = 12'h8FF;
  localparam logic [CAUSE_W-1:0] CAUSE_VALID = 17'h116BF;

  localparam logic [REG_AW-1:0] A_RAW      = 5'h00;
  localparam logic [REG_AW-1:0] A_MSKD     = 5'h01;
  localparam logic [REG_AW-1:0] A_MASK     = 5'h02;
  localparam logic [REG_AW-1:0] A_RXTHR    = 5'h03;
  localparam logic [REG_AW-1:0] A_TXTHR    = 5'h04;
  localparam logic [REG_AW-1:0] A_CAUSE    = 5'h05;
  localparam logic [REG_AW-1:0] A_CLR_ALL  = 5'h10;
  localparam logic [REG_AW-1:0] A_CLR_BASE = 5'h11;
  localparam logic [REG_AW-1:0] A_CLR_ABRT = 5'h14;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set has priority so an event coinciding with its clear is kept
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/irq_thresh_reg.sv
module irq_thresh_reg #(
  parameter int THR_W = 8,
  parameter int LVL_W = 5,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [THR_W-1:0] wdata,
  output logic [THR_W-1:0] prog,
  output logic [LVL_W-1:0] eff
);
  always_ff @(posedge clk) begin
    if (!rst_n)  prog <= '0;
    else if (we) prog <= wdata;
  end

  // programmed values beyond the FIFO depth saturate at the depth
  assign eff = (prog >= THR_W'(DEPTH)) ? LVL_W'(DEPTH) : prog[LVL_W-1:0];
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int             W     = 17,
  parameter logic [W-1:0]   VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] cause,
  input  logic         clr,
  output logic [W-1:0] q
);
  logic [W-1:0] base;
  assign base = clr ? '0 : q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= base | (cause & VALID);
    else           q <= base;
  end
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int THR_W      = 8,
  parameter int DATA_W     = 32,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_gen_call,
  input  logic               ev_start,
  input  logic               ev_stop,
  input  logic               ev_activity,
  input  logic               ev_abort,
  input  logic [CAUSE_W-1:0] abort_cause,
  input  logic               bus_active,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               ev_tx_wr_full,
  input  logic               ev_rx_drop,
  input  logic               ev_rx_rd_empty,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [IRQ_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq,
  output logic               tx_flush
);
  logic [N_STICKY-1:0] flag_q, flag_set, flag_clr;
  logic [IRQ_W-1:0]    raw_stat, mask_q, masked;
  logic [CAUSE_W-1:0]  cause_q;
  logic [THR_W-1:0]    tx_prog, rx_prog;
  logic [LVL_W-1:0]    tx_eff, rx_eff;
  logic                rd_clr_all, rd_clr_abrt;

  assign flag_set = {ev_gen_call, ev_start, ev_stop, ev_activity,
                     ev_abort, ev_tx_wr_full, ev_rx_drop, ev_rx_rd_empty};

  assign rd_clr_all  = reg_rd && (reg_addr == A_CLR_ALL);
  assign rd_clr_abrt = reg_rd && (reg_addr == A_CLR_ABRT);

  for (genvar k = 0; k < N_STICKY; k++) begin : g_flag
    logic hit;
    assign hit = rd_clr_all || (reg_rd && (reg_addr == A_CLR_BASE + REG_AW'(k)));
    if (k == K_ACT) begin : g_guard
      assign flag_clr[k] = hit && !bus_active;
    end else begin : g_plain
      assign flag_clr[k] = hit;
    end
    irq_flag_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set[k]),
      .clr  (flag_clr[k]),
      .q    (flag_q[k])
    );
  end

  irq_cause_reg #(.W(CAUSE_W), .VALID(CAUSE_VALID)) u_cause (
    .clk  (clk),
    .rst_n(rst_n),
    .load (ev_abort),
    .cause(abort_cause),
    .clr  (rd_clr_all || rd_clr_abrt),
    .q    (cause_q)
  );

  irq_thresh_reg #(.THR_W(THR_W), .LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_tx_thr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_wr && (reg_addr == A_TXTHR)),
    .wdata(reg_wdata[THR_W-1:0]),
    .prog (tx_prog),
    .eff  (tx_eff)
  );

  irq_thresh_reg #(.THR_W(THR_W), .LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)) u_rx_thr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_wr && (reg_addr == A_RXTHR)),
    .wdata(reg_wdata[THR_W-1:0]),
    .prog (rx_prog),
    .eff  (rx_eff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                             mask_q <= MASK_RST;
    else if (reg_wr && reg_addr == A_MASK)  mask_q <= reg_wdata;
  end

  always_comb begin
    raw_stat = '0;
    for (int i = 0; i < N_STICKY; i++) raw_stat[STICKY_BIT[i]] = flag_q[i];
    raw_stat[B_TXE] = (tx_level <= tx_eff);
    raw_stat[B_RXF] = (rx_level >= rx_eff);
  end

  assign masked   = raw_stat & mask_q;
  assign irq      = |masked;
  assign tx_flush = flag_q[K_ABRT];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RAW:     reg_rdata = DATA_W'(raw_stat);
      A_MSKD:    reg_rdata = DATA_W'(masked);
      A_MASK:    reg_rdata = DATA_W'(mask_q);
      A_RXTHR:   reg_rdata = DATA_W'(rx_prog);
      A_TXTHR:   reg_rdata = DATA_W'(tx_prog);
      A_CAUSE:   reg_rdata = DATA_W'(cause_q);
      A_CLR_ALL: reg_rdata[0] = |flag_q;
      default: begin
        for (int i = 0; i < N_STICKY; i++)
          if (reg_addr == A_CLR_BASE + REG_AW'(i)) reg_rdata[0] = flag_q[i];
      end
    endcase
  end
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_abort,
  input logic               ev_stop,
  input logic               bus_active,
  input logic [LVL_W-1:0]   tx_level,
  input logic               reg_rd,
  input logic [REG_AW-1:0]  reg_addr,
  input logic               tx_flush,
  input logic [IRQ_W-1:0]   raw_stat,
  input logic [CAUSE_W-1:0] cause_q
);
  logic rd_release;
  assign rd_release = reg_rd && (reg_addr == A_CLR_ABRT || reg_addr == A_CLR_ALL);

  a_r6_abort_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> tx_flush);

  a_r6_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !rd_release) |=> tx_flush);

  a_r7_activity_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[8] && bus_active) |=> raw_stat[8]);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> raw_stat[9]);

  a_r3_empty_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> raw_stat[4]);

  a_r8_cause_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLR_ALL && !ev_abort) |=> (cause_q == '0));
endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(.LVL_W(LVL_W)) chk_i (.*);

// File: tb/i2c_irq_unit_tb_top.sv
module i2c_irq_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_gen_call, ev_start, ev_stop, ev_activity, ev_abort;
  logic [16:0] abort_cause;
  logic bus_active;
  logic [4:0] tx_level, rx_level;
  logic ev_tx_wr_full, ev_rx_drop, ev_rx_rd_empty;
  logic reg_wr, reg_rd;
  logic [4:0] reg_addr;
  logic [11:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic irq, tx_flush;

  always #10 clk = ~clk;

  i2c_irq_unit dut_i (.*);

  int n_chk = 0, n_fail = 0;
  localparam int EVB [8] = '{0, 1, 3, 6, 8, 9, 10, 11};

  logic [11:0] m_st;
  logic [16:0] m_cause;
  logic [7:0]  m_txt, m_rxt;
  logic [11:0] m_mask;

  function automatic int eff(input logic [7:0] t);
    return (t > 8'd16) ? 16 : int'(t);
  endfunction

  function automatic logic [11:0] exp_raw();
    logic [11:0] r = m_st;
    r[4] = int'(tx_level) <= eff(m_txt);
    r[2] = int'(rx_level) >= eff(m_rxt);
    return r;
  endfunction

  function automatic logic sticky_any();
    logic a = 1'b0;
    for (int k = 0; k < 8; k++) a |= m_st[EVB[k]];
    return a;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, expv);
    end
  endtask

  // one cycle window: events and an optional read/write, driven at a falling edge
  task automatic step(input logic [7:0] ev, input logic [16:0] cause,
                      input logic rd, input logic wr, input logic [4:0] a,
                      input logic [11:0] wd, output logic [31:0] d);
    {ev_gen_call, ev_start, ev_stop, ev_activity, ev_abort,
     ev_tx_wr_full, ev_rx_drop, ev_rx_rd_empty} = ev;
    abort_cause = cause;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #2 d = reg_rdata;
    if (rd && a == 5'h10) chk("R10 clear-all return", d, {31'b0, sticky_any()});
    if (rd && a >= 5'h11 && a <= 5'h18)
      chk("R10 clear return", d, {31'b0, m_st[EVB[int'(a) - 17]]});
    @(negedge clk);
    {ev_gen_call, ev_start, ev_stop, ev_activity, ev_abort,
     ev_tx_wr_full, ev_rx_drop, ev_rx_rd_empty} = '0;
    abort_cause = '0; reg_rd = 0; reg_wr = 0;
    if (rd && a == 5'h10) begin
      for (int k = 0; k < 8; k++) if (k != 4 || !bus_active) m_st[EVB[k]] = 1'b0;
      m_cause = '0;
    end
    if (rd && a >= 5'h11 && a <= 5'h18) begin
      int k = int'(a) - 17;
      if (k != 4 || !bus_active) m_st[EVB[k]] = 1'b0;
      if (k == 3) m_cause = '0;
    end
    if (wr && a == 5'h02) m_mask = wd;
    if (wr && a == 5'h03) m_rxt = wd[7:0];
    if (wr && a == 5'h04) m_txt = wd[7:0];
    for (int k = 0; k < 8; k++) if (ev[k]) m_st[EVB[k]] = 1'b1;
    if (ev[3]) m_cause |= cause & 17'h116BF;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    step(8'h0, 17'h0, 1'b1, 1'b0, a, 12'h0, d);
  endtask

  task automatic wr(input logic [4:0] a, input logic [11:0] wd);
    logic [31:0] d;
    step(8'h0, 17'h0, 1'b0, 1'b1, a, wd, d);
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    logic [11:0] e = exp_raw();
    chk({req, " raw"}, 32'(irq), 32'(|(e & m_mask)));
    chk({req, " flush"}, 32'(tx_flush), 32'(m_st[6]));
    rd(5'h00, d); chk({req, " raw"}, d, 32'(e));
    rd(5'h01, d); chk({req, " R9 masked"}, d, 32'(e & m_mask));
    rd(5'h05, d); chk({req, " R6 cause"}, d, 32'(m_cause));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    rst_n = 0; bus_active = 0; tx_level = 0; rx_level = 0;
    {ev_gen_call, ev_start, ev_stop, ev_activity, ev_abort,
     ev_tx_wr_full, ev_rx_drop, ev_rx_rd_empty} = '0;
    abort_cause = 0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    m_st = 0; m_cause = 0; m_txt = 0; m_rxt = 0; m_mask = 12'h8FF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(5'h02, d); chk("R1 mask reset", d, 32'h8FF);
    rd(5'h03, d); chk("R1 rx thr reset", d, 0);
    rd(5'h04, d); chk("R1 tx thr reset", d, 0);
    rd(5'h00, d); chk("R1 raw reset (R3 R4 bits)", d, 32'h014);
    check_all("R1");

    // R2 saturation, R3 and R4 edges
    wr(5'h04, 12'd200); rd(5'h04, d); chk("R2 tx thr readback", d, 200);
    tx_level = 16; check_all("R2 R3 tx 16 thr 200");
    wr(5'h04, 12'd15); check_all("R3 tx 16 thr 15");
    tx_level = 15; check_all("R3 tx 15 thr 15");
    wr(5'h03, 12'd100); rx_level = 16; check_all("R2 R4 rx 16 thr 100");
    rx_level = 15; check_all("R4 rx 15");
    wr(5'h03, 12'd15); check_all("R4 rx 15 thr 15");

    // R5 R10 each sticky flag then its clear
    for (int k = 0; k < 8; k++) begin
      step(8'(1 << k), 17'h1FFFF, 1'b0, 1'b0, 5'h0, 12'h0, d);
      check_all("R5 R6 set");
      rd(5'(17 + k), d);
      rd(5'(17 + k), d);
      check_all("R5 R6 cleared");
    end

    // R7 activity guard
    bus_active = 1;
    step(8'h10, 17'h0, 1'b0, 1'b0, 5'h0, 12'h0, d);
    rd(5'h15, d); check_all("R7 act clear busy");
    rd(5'h10, d); check_all("R7 clear-all busy");
    bus_active = 0;
    rd(5'h15, d); check_all("R7 act clear idle");

    // R8 global clear
    step(8'hFF, 17'h00009, 1'b0, 1'b0, 5'h0, 12'h0, d);
    check_all("R8 all set");
    rd(5'h10, d); check_all("R8 cleared");

    // R11 set wins
    step(8'h20, 17'h0, 1'b0, 1'b0, 5'h0, 12'h0, d);
    step(8'h20, 17'h0, 1'b1, 1'b0, 5'h16, 12'h0, d);
    check_all("R11 stop");
    step(8'h08, 17'h00001, 1'b0, 1'b0, 5'h0, 12'h0, d);
    step(8'h08, 17'h01000, 1'b1, 1'b0, 5'h14, 12'h0, d);
    check_all("R11 abort");

    // R9 masking
    wr(5'h02, 12'h000); check_all("R9 mask zero");
    wr(5'h02, 12'h200); check_all("R9 mask stop");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 6);
      case (op)
        0, 1: step(8'($urandom), 17'($urandom), 1'b0, 1'b0, 5'h0, 12'h0, d);
        2: rd(5'($urandom_range(16, 24)), d);
        3: step(8'($urandom), 17'($urandom), 1'b1, 1'b0,
                5'($urandom_range(16, 24)), 12'h0, d);
        4: begin tx_level = 5'($urandom_range(0, 16)); rx_level = 5'($urandom_range(0, 16)); end
        5: wr(5'($urandom_range(2, 4)), 12'($urandom));
        default: bus_active = 1'($urandom);
      endcase
      if (op == 4) @(negedge clk);
      check_all("R3 R4 R5 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule